// File: doc/BRIEF.md
# Pin I/O Controller with Per-Pin Interrupt Detection

This block drives and samples a small group of general-purpose pins through a word-addressed register interface. Every pin has three pieces of state: a direction bit, an output latch and a two-stage input synchroniser. The input-data register and the interrupt logic both see the value from that synchroniser. Each pin also has an interrupt detector with a three-bit mode code, its own enable, its own mask and its own status bit. A single interrupt line is raised while any status bit is set and its mask is clear.

Software controls the interrupts through write-one registers. One register sets mask bits, a second clears mask bits, and a third clears status bits. A register that shows the status with masked pins removed lets the handler find the pins that need service. A soft-reset register puts every other register back to its reset value.

With the default of twelve pins, the mode codes are split over two registers. With eight pins or fewer, the second mode register reads as zero and has no effect.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After `rst_n` is asserted, every register reads zero. In addition, `pin_oe`, `pin_out` and `irq_out` are all zero.
- R2: The word index `bus_word` selects the register. The map is:
  - 0: enable
  - 1: status
  - 2: masked status
  - 3: status clear
  - 4: mask set
  - 5: mask clear
  - 6: output latch
  - 7: input data
  - 8: direction
  - 9: mode 0
  - 10: mode 1
  - 14: pin-use select
  - 15: soft reset

  The enable, output, direction and pin-use registers hold NUM_PINS bits. Word 4 reads back the mask. Words 3, 5 and 11 to 13 read as zero, and writes to words 11 to 13 are ignored.
- R3: `pin_oe` equals the direction register, where 1 means the pin is an output. `pin_out` equals the output latch. Neither changes unless software writes it or the block goes through a soft reset.
- R4: The input-data register shows `pin_in` after two clock edges. After only one edge it still shows the old value.
- R5: Mode code 000 is falling edge. A high-to-low change on an enabled pin sets its status bit on the third rising edge after the change; after the second edge the bit is still clear. A low-to-high change leaves the status bit clear.
- R6: Mode code 001 is rising edge. It uses the same timing as R5, and a high-to-low change leaves the status bit clear.
- R7: Any mode code with bit 2 set (1xx) detects both edges.
- R8: Code 010 is level low and code 011 is level high. While the level is active, a status bit that was just cleared is 0 for one cycle and then set again.
- R9: A status bit can only become set while the pin's enable bit is 1.
- R10: Writing a 1 to a bit of word 4 masks that pin. Writing a 1 to a bit of word 5 unmasks it. Bits written as 0 do not change the mask.
- R11: Writing a 1 to a bit of word 3 clears that status bit in the next cycle. This clear takes priority over a new event in the same cycle. Bits written as 0 have no effect.
- R12: `irq_out` is high exactly when some status bit is set and its mask bit is clear. Word 2 reads the status with masked bits removed.
- R13: The mode code for pin p sits in bits [4p+2:4p] of mode 0 when p < 8, and in bits [4(p-8)+2:4(p-8)] of mode 1 when p ≥ 8. Bit 3 of each four-bit field reads as zero.
- R14: Writing 1 to bit 0 of word 15 holds every other register at zero, and writes to them are ignored while the bit stays 1. Writing 0 to the bit releases the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_word | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| pin_in | input | NUM_PINS | Raw pin levels |
| pin_out | output | NUM_PINS | Output latch values |
| pin_oe | output | NUM_PINS | Output enables (1 = drive the pin) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
On every cycle, the assertions check several properties:
- The effect of mask-set, mask-clear and status-clear writes in the following cycle.
- That no status bit rises while its enable is off.
- That the interrupt line is never high without a status bit behind it.
- That the direction outputs do not change on their own.
- That a soft reset clears the pins and the interrupt.

Only the bench scenarios can show the detection timing for each mode code on each pin. The same holds for the mapping of pins 8 to 11 onto the second mode register, the re-arming of a level interrupt one cycle after a clear, and the two-edge latency of the input read.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Register word indices
    localparam logic [3:0] W_IEN   = 4'd0;
    localparam logic [3:0] W_STAT  = 4'd1;
    localparam logic [3:0] W_DISP  = 4'd2;
    localparam logic [3:0] W_ICLR  = 4'd3;
    localparam logic [3:0] W_MSET  = 4'd4;
    localparam logic [3:0] W_MCLR  = 4'd5;
    localparam logic [3:0] W_DOUT  = 4'd6;
    localparam logic [3:0] W_DIN   = 4'd7;
    localparam logic [3:0] W_DIR   = 4'd8;
    localparam logic [3:0] W_MODE0 = 4'd9;
    localparam logic [3:0] W_MODE1 = 4'd10;
    localparam logic [3:0] W_USE   = 4'd14;
    localparam logic [3:0] W_SRST  = 4'd15;

    // Interrupt mode codes (bit 2 set selects both edges)
    localparam logic [2:0] MODE_FALL   = 3'b000;
    localparam logic [2:0] MODE_RISE   = 3'b001;
    localparam logic [2:0] MODE_LVL_LO = 3'b010;
    localparam logic [2:0] MODE_LVL_HI = 3'b011;

    localparam int unsigned FIELDS_PER_REG = 8;
    localparam int unsigned FIELD_W        = 4;
    localparam int unsigned CODE_W         = 3;

    // Writable bits of a mode register holding the given number of fields
    function automatic logic [31:0] mode_write_mask(input int unsigned fields);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < FIELDS_PER_REG; i++) begin
            if (i < fields) m[FIELD_W*i +: CODE_W] = '1;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);

    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = async_i;
        st_d.stage2 = st_q.stage1;
        st_d.prev   = st_q.stage2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stage2;
    assign prev_o = st_q.prev;

endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N = 12
) (
    input  logic [N-1:0]             sync_i,
    input  logic [N-1:0]             prev_i,
    input  logic [N-1:0][CODE_W-1:0] code_i,
    output logic [N-1:0]             evt_o
);

    for (genvar p = 0; p < N; p++) begin : g_pin
        logic rise, fall;
        assign rise = sync_i[p] & ~prev_i[p];
        assign fall = ~sync_i[p] & prev_i[p];

        always_comb begin
            if (code_i[p][2]) begin
                evt_o[p] = rise | fall;
            end else begin
                case (code_i[p])
                    MODE_FALL:   evt_o[p] = fall;
                    MODE_RISE:   evt_o[p] = rise;
                    MODE_LVL_LO: evt_o[p] = ~sync_i[p];
                    MODE_LVL_HI: evt_o[p] = sync_i[p];
                    default:     evt_o[p] = 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [3:0]          bus_word,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq_out
);

    localparam int unsigned N = NUM_PINS;
    localparam int unsigned MODE0_FIELDS = (N < FIELDS_PER_REG) ? N : FIELDS_PER_REG;
    localparam int unsigned MODE1_FIELDS = (N > FIELDS_PER_REG) ? N - FIELDS_PER_REG : 0;
    localparam logic [31:0] MODE0_WMASK  = mode_write_mask(MODE0_FIELDS);
    localparam logic [31:0] MODE1_WMASK  = mode_write_mask(MODE1_FIELDS);

    typedef struct packed {
        logic [N-1:0] ien;
        logic [N-1:0] stat;
        logic [N-1:0] mask;
        logic [N-1:0] dout;
        logic [N-1:0] dir;
        logic [N-1:0] use_sel;
        logic [31:0]  mode0;
        logic [31:0]  mode1;
        logic         srst;
    } regs_t;

    regs_t r_d, r_q;

    logic [N-1:0]             sync_v, prev_v, evt;
    logic [N-1:0][CODE_W-1:0] codes;
    logic [N-1:0]             clr_bits, mset_bits, mclr_bits;
    logic                     srst_next;

    gpio_pin_sync #(.W(N)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (sync_v),
        .prev_o  (prev_v)
    );

    for (genvar p = 0; p < N; p++) begin : g_code
        if (p < FIELDS_PER_REG) begin : g_lo
            assign codes[p] = r_q.mode0[FIELD_W*p +: CODE_W];
        end else begin : g_hi
            assign codes[p] = r_q.mode1[FIELD_W*(p-FIELDS_PER_REG) +: CODE_W];
        end
    end

    gpio_event_detect #(.N(N)) detect_i (
        .sync_i (sync_v),
        .prev_i (prev_v),
        .code_i (codes),
        .evt_o  (evt)
    );

    // Next-state computation for the whole register file
    always_comb begin
        r_d       = r_q;
        clr_bits  = '0;
        mset_bits = '0;
        mclr_bits = '0;
        srst_next = r_q.srst;

        if (bus_wr && bus_word == W_SRST) srst_next = bus_wdata[0];

        if (bus_wr && !r_q.srst) begin
            case (bus_word)
                W_IEN:   r_d.ien     = bus_wdata[N-1:0];
                W_ICLR:  clr_bits    = bus_wdata[N-1:0];
                W_MSET:  mset_bits   = bus_wdata[N-1:0];
                W_MCLR:  mclr_bits   = bus_wdata[N-1:0];
                W_DOUT:  r_d.dout    = bus_wdata[N-1:0];
                W_DIR:   r_d.dir     = bus_wdata[N-1:0];
                W_MODE0: r_d.mode0   = bus_wdata & MODE0_WMASK;
                W_MODE1: r_d.mode1   = bus_wdata & MODE1_WMASK;
                W_USE:   r_d.use_sel = bus_wdata[N-1:0];
                default: ;
            endcase
        end

        r_d.mask = (r_q.mask | mset_bits) & ~mclr_bits;
        // clear wins over a same-cycle event; a level event re-sets next cycle
        r_d.stat = (r_q.stat | (evt & r_q.ien)) & ~clr_bits;

        if (r_q.srst) r_d = '0;
        r_d.srst = srst_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_word)
            W_IEN:   bus_rdata[N-1:0] = r_q.ien;
            W_STAT:  bus_rdata[N-1:0] = r_q.stat;
            W_DISP:  bus_rdata[N-1:0] = r_q.stat & ~r_q.mask;
            W_MSET:  bus_rdata[N-1:0] = r_q.mask;
            W_DOUT:  bus_rdata[N-1:0] = r_q.dout;
            W_DIN:   bus_rdata[N-1:0] = sync_v;
            W_DIR:   bus_rdata[N-1:0] = r_q.dir;
            W_MODE0: bus_rdata        = r_q.mode0;
            W_MODE1: bus_rdata        = r_q.mode1;
            W_USE:   bus_rdata[N-1:0] = r_q.use_sel;
            W_SRST:  bus_rdata[0]     = r_q.srst;
            default: bus_rdata        = '0;
        endcase
    end

    assign pin_out = r_q.dout;
    assign pin_oe  = r_q.dir;
    assign irq_out = |(r_q.stat & ~r_q.mask);

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_wr,
    input logic [3:0]   bus_word,
    input logic [N-1:0] wbits,
    input logic         wsrst,
    input logic [N-1:0] stat,
    input logic [N-1:0] ien,
    input logic [N-1:0] mask,
    input logic         srst,
    input logic [N-1:0] pin_oe,
    input logic [N-1:0] pin_out,
    input logic         irq_out
);

    assert_mask_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_word == W_MSET && !srst) |=> ((mask & $past(wbits)) == $past(wbits)));

    assert_mask_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_word == W_MCLR) |=> ((mask & $past(wbits)) == '0));

    assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_word == W_ICLR) |=> ((stat & $past(wbits)) == '0));

    assert_enable_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ~$past(stat) & ~$past(ien)) == '0));

    assert_irq_has_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|stat));

    assert_dir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_wr && bus_word == W_DIR) && !srst) |=> $stable(pin_oe));

    assert_srst_clears_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_word == W_SRST && wsrst) |=> ##1 (pin_oe == '0 && pin_out == '0 && !irq_out));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N(NUM_PINS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_word (bus_word),
    .wbits    (bus_wdata[NUM_PINS-1:0]),
    .wsrst    (bus_wdata[0]),
    .stat     (r_q.stat),
    .ien      (r_q.ien),
    .mask     (r_q.mask),
    .srst     (r_q.srst),
    .pin_oe   (pin_oe),
    .pin_out  (pin_out),
    .irq_out  (irq_out)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb_top;
    import gpio_irq_pkg::*;

    localparam int unsigned N          = 12;
    localparam time         CLK_PERIOD = 10ns;
    localparam logic [31:0] PMASK      = (32'd1 << N) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_word = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pin_oe;
    logic          irq_out;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_ctrl #(.NUM_PINS(N)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_word = w; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] w, output logic [31:0] d);
        bus_word = w;
        #1;
        d = bus_rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic soft_reset();
        wr(W_SRST, 32'd1);
        wr(W_SRST, 32'd0);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        edges(1);

        // R1: every word reads zero after reset, outputs idle
        for (int w = 0; w < 16; w++) begin
            rd(w[3:0], v);
            check("R1 reset read", v, 32'd0);
        end
        check("R1 pin_oe", {20'd0, pin_oe}, 32'd0);
        check("R1 pin_out", {20'd0, pin_out}, 32'd0);
        check("R1 irq_out", {31'd0, irq_out}, 32'd0);

        // R2 / R13: writable widths, write-only and reserved words
        wr(W_IEN, 32'hFFFF_FFFF);   rd(W_IEN, v);   check("R2 enable width", v, PMASK);
        wr(W_USE, 32'hFFFF_FFFF);   rd(W_USE, v);   check("R2 pin-use width", v, PMASK);
        wr(W_MODE0, 32'hFFFF_FFFF); rd(W_MODE0, v); check("R13 mode0 fields", v, 32'h7777_7777);
        wr(W_MODE1, 32'hFFFF_FFFF); rd(W_MODE1, v); check("R13 mode1 fields", v, 32'h0000_7777);
        for (int w = 11; w < 14; w++) begin
            wr(w[3:0], 32'hFFFF_FFFF); rd(w[3:0], v);
            check("R2 reserved word", v, 32'd0);
        end
        rd(W_ICLR, v); check("R2 clear word reads zero", v, 32'd0);
        rd(W_MCLR, v); check("R2 mask-clear word reads zero", v, 32'd0);
        wr(W_DOUT, 32'hA5A5_A5A5); rd(W_DOUT, v);
        check("R2 output latch", v, 32'hA5A5_A5A5 & PMASK);
        check("R3 pin_out follows latch", {20'd0, pin_out}, 32'hA5A5_A5A5 & PMASK);

        // R3: direction sweep, one pin at a time
        for (int k = 0; k < N; k++) begin
            wr(W_DIR, 32'd1 << k);
            check("R3 pin_oe", {20'd0, pin_oe}, 32'd1 << k);
            edges(2);
            check("R3 pin_oe held", {20'd0, pin_oe}, 32'd1 << k);
        end

        // R14: soft reset clears, writes ignored while held
        wr(W_SRST, 32'd1);
        wr(W_DOUT, 32'h0000_0FFF);
        rd(W_DOUT, v); check("R14 write ignored in reset", v, 32'd0);
        rd(W_SRST, v); check("R14 reset bit readable", v, 32'd1);
        wr(W_SRST, 32'd0);
        for (int w = 0; w < 16; w++) begin
            if (w != 7) begin
                rd(w[3:0], v);
                check("R14 cleared", v, 32'd0);
            end
        end
        check("R14 pin_oe", {20'd0, pin_oe}, 32'd0);

        // R4: two-edge input latency over several patterns
        for (int k = 0; k < 6; k++) begin
            logic [N-1:0] old_p, new_p;
            old_p = pin_in;
            new_p = N'((32'h0000_0935 * (k + 3)) ^ (32'd1 << k));
            pin_in = new_p;
            edges(1);
            rd(W_DIN, v); check("R4 one edge old", v, {20'd0, old_p});
            edges(1);
            rd(W_DIN, v); check("R4 two edges new", v, {20'd0, new_p});
        end
        pin_in = '0;
        edges(3);

        // R9: disabled pin never sets status
        soft_reset();
        wr(W_MODE0, 32'h0000_0001);
        pin_in[0] = 1'b1;
        edges(4);
        rd(W_STAT, v); check("R9 disabled no status", v, 32'd0);
        check("R9 irq quiet", {31'd0, irq_out}, 32'd0);
        wr(W_IEN, 32'd1);
        edges(2);
        rd(W_STAT, v); check("R9 past edge not latched", v, 32'd0);
        pin_in = '0;

        // R5-R8, R10-R13: every pin, every mode
        for (int p = 0; p < N; p++) begin
            for (int mi = 0; mi < 5; mi++) begin
                logic [2:0]  code;
                logic        idle;
                logic [31:0] bitp;
                string       tag;
                code = (mi < 4) ? mi[2:0] : ((p % 2) ? 3'b111 : 3'b100);
                tag  = (mi == 0) ? "R5" : (mi == 1) ? "R6" : (mi < 4) ? "R8" : "R7";
                if (p >= 8) tag = {tag, "/R13"};
                idle = (code == 3'b000 || code == 3'b010);
                bitp = 32'd1 << p;

                soft_reset();
                pin_in = '0;
                pin_in[p] = idle;
                edges(3);
                if (p < 8) wr(W_MODE0, {29'd0, code} << (4 * p));
                else       wr(W_MODE1, {29'd0, code} << (4 * (p - 8)));
                wr(W_IEN, bitp);
                rd(W_STAT, v); check({tag, " idle"}, v, 32'd0);

                pin_in[p] = ~idle;
                edges(2);
                rd(W_STAT, v); check({tag, " not yet"}, v, 32'd0);
                edges(1);
                rd(W_STAT, v); check({tag, " detected"}, v, bitp);
                check("R12 irq raised", {31'd0, irq_out}, 32'd1);
                rd(W_DISP, v); check("R12 masked status", v, bitp);

                wr(W_MSET, bitp);
                check("R10 masked irq", {31'd0, irq_out}, 32'd0);
                rd(W_DISP, v); check("R10 masked display", v, 32'd0);
                rd(W_MSET, v); check("R10 mask readback", v, bitp);
                wr(W_MCLR, ~bitp);
                rd(W_MSET, v); check("R10 zero bits keep mask", v, bitp);
                wr(W_MCLR, bitp);
                check("R10 unmasked irq", {31'd0, irq_out}, 32'd1);

                wr(W_ICLR, ~bitp);
                rd(W_STAT, v); check("R11 zero bits no clear", v, bitp);
                wr(W_ICLR, bitp);
                rd(W_STAT, v); check("R11 cleared", v, 32'd0);
                if (mi == 2 || mi == 3) begin
                    edges(1);
                    rd(W_STAT, v); check("R8 level re-arms", v, bitp);
                    pin_in[p] = idle;
                    edges(3);
                    wr(W_ICLR, bitp);
                    edges(2);
                    rd(W_STAT, v); check("R8 released level quiet", v, 32'd0);
                end else begin
                    pin_in[p] = idle;
                    edges(4);
                    rd(W_STAT, v);
                    check({tag, " return edge"}, v, (mi == 4) ? bitp : 32'd0);
                end
            end
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule